// File: doc/BRIEF.md
# Raster Operation Unit with Pattern Fill

This block computes one output pixel per accepted input pixel. Each pixel has three operands: the source, the destination, and a third operand. The result is formed by an 8-bit raster-operation code that works as a truth table over those operands. The third operand is either a programmable foreground colour or a texel from an 8x8 pattern. The pattern is held in a register file of 64 RGB565 words. A texel is chosen by adding programmable X/Y offsets to the pixel's coordinates, with the sum wrapping inside the tile.

Pixels arrive on a valid/ready stream that carries source, destination, x and y. Each operand pixel holds a 16-bit RGB565 colour in its low bits. An optional alpha field sits above the colour. The raster operation touches only the colour bits, and the alpha field of the result is copied from the destination.

Results leave on a registered valid/ready stream. That stream is controlled by a two-state output machine:
- `OUT_EMPTY` moves to `OUT_FULL` when a pixel is accepted (FILL).
- `OUT_FULL` stays in `OUT_FULL` in two cases:
  - when it drains and accepts in the same cycle (REPLACE);
  - when the consumer stalls (HOLD).
- `OUT_FULL` returns to `OUT_EMPTY` when it drains with no new pixel (DRAIN).

Top module: `rop_pattern_unit`

## Requirements
- R1: After reset the output stream is empty and `in_ready` is 1. The reset configuration is:
  - raster code 0xF0;
  - foreground selected as the third operand;
  - foreground colour 0;
  - both offsets 0;
  - all 64 pattern words 0.
- R2: For each colour bit i, result[i] = code[{s[i], d[i], p[i]}], where s is the source bit (weight 4), d is the destination bit (weight 2) and p is the third-operand bit (weight 1). So 0xF0 copies the source, 0xCC copies the destination and 0xAA copies the third operand. The code is written at configuration address 0, data bits 7:0.
- R3: Codes built by bitwise logic on those masks act as the matching logic function: 0xC0 yields source AND destination, and 0xFA yields source OR third operand.
- R4: Configuration address 1, data bit 0, selects the third operand: 1 picks the pattern texel, 0 picks the foreground colour. The foreground colour is written at address 2, data bits 15:0.
- R5: The texel index is (((offY + y) & 7) << 3) + ((offX + x) & 7). offX is written at configuration address 3, data bits 2:0, and offY at address 3, data bits 5:3. Higher coordinate bits have no effect.
- R6: A pattern write at 6-bit address a updates only entry a. All other entries keep their contents.
- R7: The alpha field (pixel bits 23:16) of the result equals the destination's alpha field, whatever the code, the source alpha or the third operand.
- R8: A pixel accepted at a clock edge is presented on `out_pixel` with `out_valid` high right after that edge, which is one cycle of latency.
- R9: `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_pixel` holds its value. Results leave in acceptance order.
- R10: A configuration or pattern write in the same cycle as a pixel acceptance takes effect only from the next pixel. The accepted pixel uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Configuration register address (0 code, 1 select, 2 foreground, 3 offsets) |
| cfg_wdata | input | 16 | Configuration write data |
| pat_we | input | 1 | Pattern word write strobe |
| pat_addr | input | 6 | Pattern word address (row*8 + column) |
| pat_wdata | input | 16 | Pattern word, RGB565 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel ready |
| in_src | input | 24 | Source pixel: alpha 23:16, RGB565 15:0 |
| in_dst | input | 24 | Destination pixel: alpha 23:16, RGB565 15:0 |
| in_x | input | 12 | Pixel x coordinate |
| in_y | input | 12 | Pixel y coordinate |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel ready |
| out_pixel | output | 24 | Result pixel: alpha from destination, colour from raster operation |

## Verification
A register or pattern write can land in the same cycle as a pixel acceptance, and both touch the value the pixel will use. The bench raises the write strobe and `in_valid` together while `out_ready` is held high, so acceptance is certain. The scoreboard expects that pixel to be computed with the old register contents. It expects a second pixel at the same coordinates to show the newly written value. Acceptance and drain also coincide under a toggling `out_ready`, and there the scoreboard judges order and data.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int ROP_W      = 8;
    localparam int CFG_ADDR_W = 2;

    localparam logic [CFG_ADDR_W-1:0] CFG_ROP = 2'd0;
    localparam logic [CFG_ADDR_W-1:0] CFG_SEL = 2'd1;
    localparam logic [CFG_ADDR_W-1:0] CFG_FG  = 2'd2;
    localparam logic [CFG_ADDR_W-1:0] CFG_OFF = 2'd3;

    localparam logic [ROP_W-1:0] ROP_RESET = 8'hF0;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/rop_cfg_file.sv
module rop_cfg_file
    import rop_pkg::*;
#(
    parameter int COLOR_W  = 16,
    parameter int PAT_LOG2 = 3,
    localparam int IDX_W     = 2 * PAT_LOG2,
    localparam int PAT_DEPTH = 1 << IDX_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [COLOR_W-1:0]    cfg_wdata,
    input  logic                  pat_we,
    input  logic [IDX_W-1:0]      pat_addr,
    input  logic [COLOR_W-1:0]    pat_wdata,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [COLOR_W-1:0]    rd_word,
    output logic [ROP_W-1:0]      rop_code,
    output logic                  use_pattern,
    output logic [COLOR_W-1:0]    fg_color,
    output logic [PAT_LOG2-1:0]   off_x,
    output logic [PAT_LOG2-1:0]   off_y
);

    logic [ROP_W-1:0]   rop_q;
    logic               sel_q;
    logic [COLOR_W-1:0] fg_q;
    logic [IDX_W-1:0]   off_q;
    logic [COLOR_W-1:0] pat_mem [PAT_DEPTH];

    // Scalar configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rop_q <= ROP_RESET;
            sel_q <= 1'b0;
            fg_q  <= '0;
            off_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_ROP: rop_q <= cfg_wdata[ROP_W-1:0];
                CFG_SEL: sel_q <= cfg_wdata[0];
                CFG_FG:  fg_q  <= cfg_wdata;
                CFG_OFF: off_q <= cfg_wdata[IDX_W-1:0];
            endcase
        end
    end

    // One register per pattern word, each with its own address match
    for (genvar e = 0; e < PAT_DEPTH; e++) begin : g_pat_word
        always_ff @(posedge clk) begin
            if (rst) begin
                pat_mem[e] <= '0;
            end else if (pat_we && (pat_addr == IDX_W'(e))) begin
                pat_mem[e] <= pat_wdata;
            end
        end
    end

    assign rd_word     = pat_mem[rd_idx];
    assign rop_code    = rop_q;
    assign use_pattern = sel_q;
    assign fg_color    = fg_q;
    assign off_x       = off_q[PAT_LOG2-1:0];
    assign off_y       = off_q[IDX_W-1:PAT_LOG2];

    assert_pat_write_R6: assert property (@(posedge clk) disable iff (rst)
        pat_we |=> pat_mem[$past(pat_addr)] == $past(pat_wdata));

    assert_rop_store_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_ROP) |=> rop_code == $past(cfg_wdata[ROP_W-1:0]));

    assert_sel_store_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_SEL) |=> use_pattern == $past(cfg_wdata[0]));

endmodule

// File: rtl/rop_third_operand.sv
module rop_third_operand #(
    parameter int COLOR_W  = 16,
    parameter int COORD_W  = 12,
    parameter int PAT_LOG2 = 3,
    localparam int IDX_W = 2 * PAT_LOG2
) (
    input  logic [COORD_W-1:0]  x,
    input  logic [COORD_W-1:0]  y,
    input  logic [PAT_LOG2-1:0] off_x,
    input  logic [PAT_LOG2-1:0] off_y,
    input  logic                use_pattern,
    input  logic [COLOR_W-1:0]  fg_color,
    input  logic [COLOR_W-1:0]  pat_word,
    output logic [IDX_W-1:0]    pat_idx,
    output logic [COLOR_W-1:0]  third
);

    logic [PAT_LOG2-1:0] col;
    logic [PAT_LOG2-1:0] row;
    logic                unused_coord_hi;

    // Sums are kept at tile width, so they wrap inside the 8x8 tile
    assign col     = off_x + x[PAT_LOG2-1:0];
    assign row     = off_y + y[PAT_LOG2-1:0];
    assign pat_idx = {row, col};
    assign third   = use_pattern ? pat_word : fg_color;

    assign unused_coord_hi = ^{x[COORD_W-1:PAT_LOG2], y[COORD_W-1:PAT_LOG2]};

endmodule

// File: rtl/rop_bit_lanes.sv
module rop_bit_lanes
    import rop_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [ROP_W-1:0] rop_code,
    input  logic [WIDTH-1:0] s,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] p,
    output logic [WIDTH-1:0] res
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        assign res[b] = rop_code[{s[b], d[b], p[b]}];
    end

    always_comb begin
        if (rop_code == 8'hF0) begin
            assert_src_copy_R2: assert (res == s);
        end
        if (rop_code == 8'hCC) begin
            assert_dst_copy_R2: assert (res == d);
        end
    end

endmodule

// File: rtl/rop_pattern_unit.sv
module rop_pattern_unit
    import rop_pkg::*;
#(
    parameter int COLOR_W  = 16,
    parameter int ALPHA_W  = 8,
    parameter int COORD_W  = 12,
    parameter int PAT_LOG2 = 3,
    localparam int PIX_W = COLOR_W + ALPHA_W,
    localparam int IDX_W = 2 * PAT_LOG2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [COLOR_W-1:0]    cfg_wdata,
    input  logic                  pat_we,
    input  logic [IDX_W-1:0]      pat_addr,
    input  logic [COLOR_W-1:0]    pat_wdata,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_src,
    input  logic [PIX_W-1:0]      in_dst,
    input  logic [COORD_W-1:0]    in_x,
    input  logic [COORD_W-1:0]    in_y,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PIX_W-1:0]      out_pixel
);

    out_state_e state_q;
    out_state_e state_d;

    logic [ROP_W-1:0]    rop_code;
    logic                use_pattern;
    logic [COLOR_W-1:0]  fg_color;
    logic [PAT_LOG2-1:0] off_x;
    logic [PAT_LOG2-1:0] off_y;
    logic [IDX_W-1:0]    pat_idx;
    logic [COLOR_W-1:0]  pat_word;
    logic [COLOR_W-1:0]  third;
    logic [COLOR_W-1:0]  color_res;
    logic [PIX_W-1:0]    result;
    logic [PIX_W-1:0]    pixel_q;
    logic                accept;
    logic                drain;

    rop_cfg_file #(
        .COLOR_W  (COLOR_W),
        .PAT_LOG2 (PAT_LOG2)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .pat_we      (pat_we),
        .pat_addr    (pat_addr),
        .pat_wdata   (pat_wdata),
        .rd_idx      (pat_idx),
        .rd_word     (pat_word),
        .rop_code    (rop_code),
        .use_pattern (use_pattern),
        .fg_color    (fg_color),
        .off_x       (off_x),
        .off_y       (off_y)
    );

    rop_third_operand #(
        .COLOR_W  (COLOR_W),
        .COORD_W  (COORD_W),
        .PAT_LOG2 (PAT_LOG2)
    ) u_operand (
        .x           (in_x),
        .y           (in_y),
        .off_x       (off_x),
        .off_y       (off_y),
        .use_pattern (use_pattern),
        .fg_color    (fg_color),
        .pat_word    (pat_word),
        .pat_idx     (pat_idx),
        .third       (third)
    );

    rop_bit_lanes #(
        .WIDTH (COLOR_W)
    ) u_lanes (
        .rop_code (rop_code),
        .s        (in_src[COLOR_W-1:0]),
        .d        (in_dst[COLOR_W-1:0]),
        .p        (third),
        .res      (color_res)
    );

    // Alpha field, when present, bypasses the raster operation
    if (ALPHA_W > 0) begin : g_alpha
        assign result = {in_dst[PIX_W-1:COLOR_W], color_res};

        assert_alpha_pass_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> out_pixel[PIX_W-1:COLOR_W] == $past(in_dst[PIX_W-1:COLOR_W]));
    end else begin : g_no_alpha
        assign result = color_res;
    end

    // Output stage state machine
    assign accept = in_valid && in_ready;
    assign drain  = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            OUT_EMPTY: begin
                in_ready = 1'b1;
                if (accept) begin
                    state_d = OUT_FULL;          // FILL
                end
            end
            OUT_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (drain && !accept) begin
                    state_d = OUT_EMPTY;         // DRAIN
                end else begin
                    state_d = OUT_FULL;          // REPLACE or HOLD
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pixel_q <= '0;
        end else if (accept) begin
            pixel_q <= result;
        end
    end

    assign out_pixel = pixel_q;

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

endmodule

// File: tb/test_rop_pattern_unit.sv
`timescale 1ns/1ps
module test_rop_pattern_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        pat_we = 1'b0;
    logic [5:0]  pat_addr = '0;
    logic [15:0] pat_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_src = '0;
    logic [23:0] in_dst = '0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pixel;

    int n_checks = 0;
    int n_errors = 0;

    // Bench-side copy of the programmed configuration
    logic [7:0]  sh_rop = 8'hF0;
    logic        sh_sel = 1'b0;
    logic [15:0] sh_fg = '0;
    logic [2:0]  sh_offx = '0;
    logic [2:0]  sh_offy = '0;
    logic [15:0] sh_pat [64];

    logic [23:0] exp_q [$];
    string       tag_q [$];
    logic [23:0] mon_exp;
    string       mon_tag;

    logic stall_mode = 1'b0;
    int   ready_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    rop_pattern_unit i_rop_pattern_unit (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pat_we    (pat_we),
        .pat_addr  (pat_addr),
        .pat_wdata (pat_wdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_src    (in_src),
        .in_dst    (in_dst),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pixel (out_pixel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input logic [23:0] s, input logic [23:0] d,
                                          input logic [11:0] x, input logic [11:0] y);
        logic [2:0]  c;
        logic [2:0]  r;
        logic [15:0] p;
        logic [15:0] res;
        c = sh_offx + x[2:0];
        r = sh_offy + y[2:0];
        p = sh_sel ? sh_pat[{r, c}] : sh_fg;
        for (int i = 0; i < 16; i++) begin
            res[i] = sh_rop[{s[i], d[i], p[i]}];
        end
        return {d[23:16], res};
    endfunction

    function automatic void shadow_cfg(input logic [1:0] a, input logic [15:0] v);
        case (a)
            2'd0: sh_rop = v[7:0];
            2'd1: sh_sel = v[0];
            2'd2: sh_fg = v;
            default: begin
                sh_offx = v[2:0];
                sh_offy = v[5:3];
            end
        endcase
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shadow_cfg(a, v);
    endtask

    task automatic pat_write(input logic [5:0] a, input logic [15:0] v);
        @(posedge clk); #1;
        pat_we = 1'b1; pat_addr = a; pat_wdata = v;
        @(posedge clk); #1;
        pat_we = 1'b0;
        sh_pat[a] = v;
    endtask

    // Driver: offers one pixel, pushes its expected result when accepted
    task automatic send(input logic [23:0] s, input logic [23:0] d,
                        input logic [11:0] x, input logic [11:0] y, input string tag);
        logic ok;
        @(posedge clk); #1;
        in_valid = 1'b1; in_src = s; in_dst = d; in_x = x; in_y = y;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
        end while (!ok);
        exp_q.push_back(model(s, d, x, y));
        tag_q.push_back(tag);
        #1;
        in_valid = 1'b0;
    endtask

    // R10: pixel offered in the same cycle as a pattern or config write
    task automatic send_with_write(input logic is_pat, input logic [5:0] a, input logic [15:0] v,
                                   input logic [23:0] s, input logic [23:0] d,
                                   input logic [11:0] x, input logic [11:0] y);
        @(posedge clk); #1;
        in_valid = 1'b1; in_src = s; in_dst = d; in_x = x; in_y = y;
        if (is_pat) begin
            pat_we = 1'b1; pat_addr = a; pat_wdata = v;
        end else begin
            cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = v;
        end
        @(negedge clk);
        check("R10 accept in write cycle", 32'(in_ready), 32'd1);
        exp_q.push_back(model(s, d, x, y));
        tag_q.push_back("R10 old value used");
        @(posedge clk); #1;
        in_valid = 1'b0; pat_we = 1'b0; cfg_we = 1'b0;
        if (is_pat) sh_pat[a] = v;
        else shadow_cfg(a[1:0], v);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R9: unexpected output %h, expected none", out_pixel);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_tag, 32'(out_pixel), 32'(mon_exp));
            end
        end
    end

    // Backpressure generator used during the burst phase
    always @(posedge clk) begin
        if (stall_mode) begin
            #1;
            ready_cnt++;
            out_ready = (ready_cnt % 3) != 0;
        end
    end

    function automatic logic [15:0] next_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [23:0] held;
        for (int i = 0; i < 64; i++) sh_pat[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);
        send(24'hA5_1234, 24'h3C_FEDC, 12'd0, 12'd0, "R1 reset code copies source");
        cfg_write(2'd0, 16'h00AA);
        send(24'h11_FFFF, 24'h22_5555, 12'd1, 12'd2, "R1 reset foreground is zero");
        cfg_write(2'd1, 16'h0001);
        send(24'h11_FFFF, 24'h22_5555, 12'd5, 12'd7, "R1 reset pattern is zero");
        cfg_write(2'd1, 16'h0000);

        // R2: basic truth-table codes with a foreground third operand
        cfg_write(2'd2, 16'h5A3C);
        cfg_write(2'd0, 16'h00CC);
        send(24'h01_F0F0, 24'h02_1357, 12'd0, 12'd0, "R2 code CC copies destination");
        cfg_write(2'd0, 16'h00AA);
        send(24'h01_F0F0, 24'h02_1357, 12'd0, 12'd0, "R2 code AA copies third operand");
        cfg_write(2'd0, 16'h00F0);
        send(24'h01_F0F0, 24'h02_1357, 12'd0, 12'd0, "R2 code F0 copies source");
        for (int k = 0; k < 12; k++) begin
            lfsr = next_lfsr(lfsr);
            cfg_write(2'd0, {8'h00, lfsr[7:0]});
            lfsr = next_lfsr(lfsr);
            send({lfsr[7:0], lfsr}, {lfsr[15:8], ~lfsr}, 12'(k), 12'(k), "R2 arbitrary code");
        end

        // Load the whole pattern
        for (int e = 0; e < 64; e++) begin
            pat_write(6'(e), 16'(e * 16'h0405) ^ 16'h1111);
        end

        // R3: combined codes
        cfg_write(2'd0, 16'h00C0);
        send(24'h00_ABCD, 24'h00_0FF0, 12'd0, 12'd0, "R3 code C0 is src AND dst");
        cfg_write(2'd1, 16'h0001);
        cfg_write(2'd0, 16'h00FA);
        send(24'h00_8001, 24'h00_FFFF, 12'd3, 12'd4, "R3 code FA is src OR pattern");

        // R4: operand select
        cfg_write(2'd0, 16'h00AA);
        send(24'h00_0000, 24'h00_0000, 12'd2, 12'd1, "R4 select=1 gives texel");
        cfg_write(2'd1, 16'h0000);
        send(24'h00_0000, 24'h00_0000, 12'd2, 12'd1, "R4 select=0 gives foreground");
        cfg_write(2'd1, 16'h0001);

        // R5: offsets and wrap, high coordinate bits ignored
        cfg_write(2'd3, 16'h002B);  // offX=3, offY=5
        send(24'h0, 24'h0, 12'd7, 12'd6, "R5 wrapped index");
        send(24'h0, 24'h0, 12'h7FD, 12'hA42, "R5 high coordinate bits");
        send(24'h0, 24'h0, 12'd4, 12'd2, "R5 offset corner");
        cfg_write(2'd3, 16'h0000);
        send(24'h0, 24'h0, 12'd7, 12'd7, "R5 last entry");

        // R6: single-entry update
        pat_write(6'd9, 16'hBEEF);
        send(24'h0, 24'h0, 12'd1, 12'd1, "R6 written entry 9");
        send(24'h0, 24'h0, 12'd0, 12'd1, "R6 neighbour entry 8 kept");
        send(24'h0, 24'h0, 12'd2, 12'd1, "R6 neighbour entry 10 kept");

        // R7: alpha from destination
        cfg_write(2'd0, 16'h00FF);
        send(24'h77_0000, 24'h9E_0000, 12'd0, 12'd0, "R7 alpha from destination");
        cfg_write(2'd0, 16'h00F0);
        send(24'hFF_1234, 24'h00_4321, 12'd0, 12'd0, "R7 source alpha dropped");

        // R8: one-cycle latency then drain
        send(24'h00_0F0F, 24'h00_0000, 12'd0, 12'd0, "R8 data");
        @(negedge clk);
        check("R8 out_valid one cycle after accept", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R8 out_valid clears after drain", 32'(out_valid), 32'd0);

        // R9: stall holds data and blocks input
        @(posedge clk); #1 out_ready = 1'b0;
        send(24'h00_C3C3, 24'h00_0000, 12'd0, 12'd0, "R9 stalled pixel");
        held = model(24'h00_C3C3, 24'h00_0000, 12'd0, 12'd0);
        fork
            send(24'h00_3C3C, 24'h00_0000, 12'd0, 12'd0, "R9 queued pixel");
            begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check("R9 in_ready low while stalled", 32'(in_ready), 32'd0);
                    check("R9 out_pixel held", 32'(out_pixel), 32'(held));
                end
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join

        // R9: burst with toggling backpressure
        stall_mode = 1'b1;
        cfg_write(2'd1, 16'h0001);
        cfg_write(2'd0, 16'h00E8);
        for (int k = 0; k < 12; k++) begin
            lfsr = next_lfsr(lfsr);
            send({lfsr[7:0], lfsr}, {lfsr[15:8], lfsr ^ 16'h5A5A}, 12'(k * 5), 12'(k * 3),
                 "R9 burst order and data");
        end
        repeat (4) @(posedge clk);
        stall_mode = 1'b0;
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (3) @(posedge clk);

        // R10: writes coinciding with acceptance
        cfg_write(2'd3, 16'h0000);
        cfg_write(2'd0, 16'h00AA);
        send_with_write(1'b1, 6'd20, 16'h7E57, 24'h0, 24'h0, 12'd4, 12'd2);
        send(24'h0, 24'h0, 12'd4, 12'd2, "R10 new pattern word next pixel");
        send_with_write(1'b0, 6'd0, 16'h00CC, 24'h00_1111, 24'h00_2222, 12'd0, 12'd0);
        send(24'h00_1111, 24'h00_2222, 12'd0, 12'd0, "R10 new code next pixel");

        repeat (5) @(posedge clk);
        check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule